// File: doc/BRIEF.md
# Programmable Bandpass Mismatch-Shaping Element Selector

This block picks which unary current elements of a segmented converter switch on for each sample. It receives a 12-bit code. The upper field is an unsigned count N of elements that must be on. The lower field belongs to the binary segment and passes through without any change. The block drives one enable bit per unary element.

The choice of elements follows a per-element loop filter. Each filter is built from identical second-order sections that place a pair of noise-transfer zeros at a programmable centre frequency. Because of this, the error caused by element mismatch moves out of a band around that frequency instead of staying near DC.

The number of cascaded sections sets the shaping order: one, two or three sections give order 2, 4 or 6. The resonator coefficient, c = 2cos(2π·f0/Fs), sets the centre of the notch. Both values are loaded through a configuration write.

Top module: `dem_bp_selector`

## Requirements
- R1: `in_code[11:7]` is the unsigned element count N. `in_code[6:0]` appears on `out_lsb` together with that sample's enables.
- R2: A sample accepted with `in_valid` high produces `out_valid` high exactly two clock edges later. While `out_valid` is low, `out_enable` is all zero.
- R3: The enable vector of a valid sample has exactly N bits set. This means none for N=0 and all 31 for N=31.
- R4: The N elements whose metric is largest are enabled. When metrics are equal, the element with the lower index wins.
- R5: Each section computes w = sat(in + floor(c·w[n−1] / 2^14) − w[n−2]), where c is a signed value with 14 fractional bits. The input of the first section is N − 31·u, with u=1 if the element was enabled for this sample and u=0 otherwise. The input of each later section is the new output of the section before it.
- R6: A section output that leaves the signed STATE_W-bit range is clamped to the nearest limit; it never wraps.
- R7: Order code 0, 1 or 2 takes the metric from the previous output of section 1, 2 or 3. Code 3 behaves like code 2. All sections always run in cascade.
- R8: When `cfg_we` is high at a clock edge, `cfg_order` and `cfg_coef` are stored. The stored values apply to the sample presented in that same cycle and to all later samples. Samples presented earlier are not affected. After reset the stored values are order code 0 and coefficient 0.
- R9: A clock edge with `rst_n` low clears all filter state and all outputs. The first sample after reset therefore enables elements 0 to N−1.
- R10: Filter state changes only for valid samples. Idle cycles leave the selection sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_order | input | 2 | Shaping order code (0: order 2, 1: order 4, 2 or 3: order 6) |
| cfg_coef | input | 16 | Resonator coefficient c, signed, 14 fractional bits |
| in_valid | input | 1 | Input sample strobe |
| in_code | input | 12 | Count field [11:7], binary field [6:0] |
| out_valid | output | 1 | Output sample strobe |
| out_enable | output | 31 | One enable bit per unary element |
| out_lsb | output | 7 | Binary field, delayed to match the enables |

## Verification
The bench keeps the default 5-bit count field, so the full 31-element ranking, all tie breaks and the extreme counts 0 and 31 are exercised. It builds the state width as 10 bits instead of 16. With a coefficient near +2 and order 6, the sections then reach the clamp within a few dozen samples. This makes the saturation corner reachable in a short run, and the bench compares every enable vector against a step-by-step arithmetic model of the sections.

// File: rtl/dem_sel_pkg.sv
// Package: shared constants and helpers for the bandpass element selector.
// Assumes the order code is two bits wide and that the number of sections is at least one.
package dem_sel_pkg;

    localparam int ORD_W = 2;

    typedef logic [ORD_W-1:0] ord_code_t;

    // Maps an order code to the index of the section that supplies the metric.
    function automatic int metric_section(input ord_code_t code, input int nsec);
        if (int'(code) >= nsec) begin
            return nsec - 1;
        end
        return int'(code);
    endfunction

endpackage

// File: rtl/dem_cfg_regs.sv
// Module: configuration store for the shaping order and the resonator coefficient.
// Assumes a write strobe that lasts one cycle; reset values select order 2 and c = 0.
module dem_cfg_regs
    import dem_sel_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  ord_code_t                order_in,
    input  logic signed [COEF_W-1:0] coef_in,
    output ord_code_t                order_q,
    output logic signed [COEF_W-1:0] coef_q
);

    // Capture the configuration on a write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= '0;
            coef_q  <= '0;
        end else if (we) begin
            order_q <= order_in;
            coef_q  <= coef_in;
        end
    end

endmodule

// File: rtl/dem_elem_filter.sv
// Module: loop filter of one unary element, a cascade of NSEC resonator sections.
// Each section computes w = sat(in + floor(c*w1 / 2^FRAC) - w2). The first input is
// cnt - NEL*used. The metric is the previous output of the section the order code picks.
// Assumes that COEF_W + STATE_W bits hold the full coefficient product.
module dem_elem_filter
    import dem_sel_pkg::*;
#(
    parameter int THERM_BITS = 5,
    parameter int STATE_W    = 16,
    parameter int COEF_W     = 16,
    parameter int COEF_FRAC  = 14,
    parameter int NSEC       = 3,
    parameter int NEL        = 31
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd,
    input  logic                      used,
    input  logic [THERM_BITS-1:0]     cnt,
    input  ord_code_t                 order,
    input  logic signed [COEF_W-1:0]  coef,
    output logic signed [STATE_W-1:0] metric
);

    localparam int PW = COEF_W + STATE_W;
    localparam int SW = PW + 1;
    localparam logic [SW-1:0] NEL_S = SW'(NEL);
    localparam logic signed [STATE_W-1:0] SAT_HI = {1'b0, {(STATE_W-1){1'b1}}};
    localparam logic signed [STATE_W-1:0] SAT_LO = {1'b1, {(STATE_W-1){1'b0}}};

    logic signed [SW-1:0]      x_s;
    logic signed [STATE_W-1:0] w1_all [NSEC];
    logic signed [PW-1:0]      coef_x;

    // Feedback input: the requested count minus the element count when this element is on.
    assign x_s    = {{(SW-THERM_BITS){1'b0}}, cnt} - (used ? NEL_S : '0);
    assign coef_x = {{STATE_W{coef[COEF_W-1]}}, coef};

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        logic signed [STATE_W-1:0] w1_q;
        logic signed [STATE_W-1:0] w2_q;
        logic signed [STATE_W-1:0] w_new;
        logic signed [PW-1:0]      w_x;
        logic signed [PW-1:0]      prod;
        logic signed [PW-1:0]      scaled;
        logic signed [SW-1:0]      sec_in;
        logic signed [SW-1:0]      sum;
        logic        [SW-STATE_W:0] hi;

        if (s == 0) begin : g_first
            assign sec_in = x_s;
        end else begin : g_chain
            assign sec_in = {{(SW-STATE_W){g_sec[s-1].w_new[STATE_W-1]}}, g_sec[s-1].w_new};
        end

        // Resonator arithmetic with a clamp to the state range.
        always_comb begin
            w_x    = {{COEF_W{w1_q[STATE_W-1]}}, w1_q};
            prod   = coef_x * w_x;
            scaled = prod >>> COEF_FRAC;
            sum    = {scaled[PW-1], scaled} + sec_in
                   - {{(SW-STATE_W){w2_q[STATE_W-1]}}, w2_q};
            hi     = sum[SW-1:STATE_W-1];
            if ((&hi) || (~|hi)) begin
                w_new = sum[STATE_W-1:0];
            end else if (sum[SW-1]) begin
                w_new = SAT_LO;
            end else begin
                w_new = SAT_HI;
            end
        end

        // Shift the section's two delay registers on every valid sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w1_q <= '0;
                w2_q <= '0;
            end else if (upd) begin
                w2_q <= w1_q;
                w1_q <= w_new;
            end
        end

        assign w1_all[s] = w1_q;
    end

    // Pick the metric from the section that the order code names.
    always_comb begin
        metric = w1_all[NSEC-1];
        for (int s = 0; s < NSEC; s++) begin
            if (s == metric_section(order, NSEC)) begin
                metric = w1_all[s];
            end
        end
    end

endmodule

// File: rtl/dem_rank_select.sv
// Module: ranks all elements by metric and enables the cnt elements that rank highest.
// An element's rank is the number of elements that beat it: a larger metric beats a
// smaller one, and on equal metrics the lower index wins. Assumes NEL < 2**CNT_W.
module dem_rank_select #(
    parameter int NEL     = 31,
    parameter int CNT_W   = 5,
    parameter int STATE_W = 16
) (
    input  logic signed [STATE_W-1:0] metric [NEL],
    input  logic [CNT_W-1:0]          cnt,
    output logic [NEL-1:0]            sel
);

    for (genvar i = 0; i < NEL; i++) begin : g_elem
        logic [CNT_W-1:0] rank;

        // Count the elements that outrank element i.
        always_comb begin
            rank = '0;
            for (int j = 0; j < NEL; j++) begin
                if (j != i) begin
                    if ((metric[j] > metric[i]) || ((metric[j] == metric[i]) && (j < i))) begin
                        rank = rank + CNT_W'(1);
                    end
                end
            end
        end

        assign sel[i] = (rank < cnt);
    end

endmodule

// File: rtl/dem_bp_selector.sv
// Module: top of the bandpass mismatch-shaping selector.
// Stage 1 registers the sample. Stage 2 ranks the element filters, registers the enables
// and updates the filters with the usage bits. Total latency is two clock edges.
// Assumes the configuration is written between samples or alongside one.
module dem_bp_selector
    import dem_sel_pkg::*;
#(
    parameter int THERM_BITS = 5,
    parameter int LSB_BITS   = 7,
    parameter int STATE_W    = 16,
    parameter int COEF_W     = 16,
    parameter int COEF_FRAC  = 14,
    parameter int NSEC       = 3,
    localparam int NEL       = (2 ** THERM_BITS) - 1,
    localparam int CODE_W    = THERM_BITS + LSB_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ORD_W-1:0]         cfg_order,
    input  logic signed [COEF_W-1:0] cfg_coef,
    input  logic                     in_valid,
    input  logic [CODE_W-1:0]        in_code,
    output logic                     out_valid,
    output logic [NEL-1:0]           out_enable,
    output logic [LSB_BITS-1:0]      out_lsb
);

    ord_code_t                 order_q;
    logic signed [COEF_W-1:0]  coef_q;
    logic                      s1_valid;
    logic [THERM_BITS-1:0]     s1_cnt;
    logic [LSB_BITS-1:0]       s1_lsb;
    logic signed [STATE_W-1:0] metric [NEL];
    logic [NEL-1:0]            sel;

    dem_cfg_regs #(.COEF_W(COEF_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .order_in (cfg_order),
        .coef_in  (cfg_coef),
        .order_q  (order_q),
        .coef_q   (coef_q)
    );

    // Stage 1: register the incoming sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_cnt   <= '0;
            s1_lsb   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_cnt   <= in_code[CODE_W-1:LSB_BITS];
            s1_lsb   <= in_code[LSB_BITS-1:0];
        end
    end

    for (genvar e = 0; e < NEL; e++) begin : g_filt
        dem_elem_filter #(
            .THERM_BITS (THERM_BITS),
            .STATE_W    (STATE_W),
            .COEF_W     (COEF_W),
            .COEF_FRAC  (COEF_FRAC),
            .NSEC       (NSEC),
            .NEL        (NEL)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (s1_valid),
            .used   (sel[e]),
            .cnt    (s1_cnt),
            .order  (order_q),
            .coef   (coef_q),
            .metric (metric[e])
        );
    end

    dem_rank_select #(
        .NEL     (NEL),
        .CNT_W   (THERM_BITS),
        .STATE_W (STATE_W)
    ) u_rank (
        .metric (metric),
        .cnt    (s1_cnt),
        .sel    (sel)
    );

    // Stage 2: register the enables and the delayed binary field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_enable <= '0;
            out_lsb    <= '0;
        end else begin
            out_valid  <= s1_valid;
            out_enable <= s1_valid ? sel : '0;
            out_lsb    <= s1_lsb;
        end
    end

endmodule

// File: rtl/dem_bp_selector_chk.sv
// Module: port-level checker for the selector, bound to every instance of the top module.
// Assumes the synchronous active-low reset of the top module.
module dem_bp_selector_chk #(
    parameter int THERM_BITS = 5,
    parameter int LSB_BITS   = 7,
    localparam int NEL       = (2 ** THERM_BITS) - 1,
    localparam int CODE_W    = THERM_BITS + LSB_BITS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [CODE_W-1:0]   in_code,
    input logic                out_valid,
    input logic [NEL-1:0]      out_enable,
    input logic [LSB_BITS-1:0] out_lsb
);

    // R2: every accepted sample leaves two edges later.
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2: no output strobe without a sample two edges earlier.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R2: enables stay clear between samples.
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_enable == '0));

    // R1: the binary field passes through.
    a_r1_lsb_pass: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lsb == $past(in_code[LSB_BITS-1:0], 2)));

    // R3: exactly N elements are enabled.
    a_r3_count: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_enable) == int'($past(in_code[CODE_W-1:LSB_BITS], 2))));

endmodule

bind dem_bp_selector dem_bp_selector_chk #(
    .THERM_BITS (THERM_BITS),
    .LSB_BITS   (LSB_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_code    (in_code),
    .out_valid  (out_valid),
    .out_enable (out_enable),
    .out_lsb    (out_lsb)
);

// File: tb/sim_dem_bp_selector.sv
// Bench: directed scenarios checked against an arithmetic model of the sections.
// Inputs change on the falling edge and outputs are sampled there too.
module sim_dem_bp_selector;

    localparam int TB_W   = 10;
    localparam int NEL    = 31;
    localparam int NSEC   = 3;
    localparam int SAT_HI = (1 << (TB_W - 1)) - 1;
    localparam int SAT_LO = -(1 << (TB_W - 1));

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_order = '0;
    logic signed [15:0] cfg_coef = '0;
    logic              in_valid = 1'b0;
    logic [11:0]       in_code = '0;
    logic              out_valid;
    logic [30:0]       out_enable;
    logic [6:0]        out_lsb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    int m_w1 [NSEC][NEL];
    int m_w2 [NSEC][NEL];
    int m_ord = 0;
    int m_coef = 0;

    // expected-output pipeline: p1 = previous call, p2 = two calls back
    bit          p1_v, p2_v;
    logic [30:0] p1_e, p2_e;
    logic [6:0]  p1_l, p2_l;
    string       p1_t, p2_t;
    bit [31:0]   lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    dem_bp_selector #(.STATE_W(TB_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_order  (cfg_order),
        .cfg_coef   (cfg_coef),
        .in_valid   (in_valid),
        .in_code    (in_code),
        .out_valid  (out_valid),
        .out_enable (out_enable),
        .out_lsb    (out_lsb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
        end
    endtask

    function automatic int sat(input int v);
        if (v > SAT_HI) return SAT_HI;
        if (v < SAT_LO) return SAT_LO;
        return v;
    endfunction

    // Model of one valid sample (R4, R5, R6, R7).
    function automatic logic [30:0] model_sample(input int n);
        int sec;
        int m [NEL];
        logic [30:0] s;
        sec = (m_ord > NSEC - 1) ? NSEC - 1 : m_ord;
        for (int i = 0; i < NEL; i++) m[i] = m_w1[sec][i];
        for (int i = 0; i < NEL; i++) begin
            int rank = 0;
            for (int j = 0; j < NEL; j++)
                if (j != i && (m[j] > m[i] || (m[j] == m[i] && j < i))) rank++;
            s[i] = (rank < n);
        end
        for (int i = 0; i < NEL; i++) begin
            int inp = n - NEL * int'(s[i]);
            for (int k = 0; k < NSEC; k++) begin
                int t = sat(inp + ((m_coef * m_w1[k][i]) >>> 14) - m_w2[k][i]);
                m_w2[k][i] = m_w1[k][i];
                m_w1[k][i] = t;
                inp = t;
            end
        end
        return s;
    endfunction

    // One cycle: check the output due now, then drive the next inputs.
    task automatic cycle(input bit v, input int n, input int lsb, input bit we,
                         input int ord, input int coef, input string tag);
        logic [30:0] e;
        @(negedge clk);
        chk(out_valid == p2_v, "R2", {tag, " out_valid"}, 64'(out_valid), 64'(p2_v));
        if (p2_v) begin
            chk(out_enable == p2_e, p2_t, "out_enable", 64'(out_enable), 64'(p2_e));
            chk(out_lsb == p2_l, "R1", "out_lsb", 64'(out_lsb), 64'(p2_l));
        end else begin
            chk(out_enable == '0, "R2", "idle out_enable", 64'(out_enable), 64'd0);
        end
        cfg_we    = we;
        cfg_order = 2'(ord);
        cfg_coef  = 16'(coef);
        in_valid  = v;
        in_code   = {5'(n), 7'(lsb)};
        if (we) begin
            m_ord  = ord;
            m_coef = coef;
        end
        e = '0;
        if (v) e = model_sample(n);
        p2_v = p1_v; p2_e = p1_e; p2_l = p1_l; p2_t = p1_t;
        p1_v = v;    p1_e = e;    p1_l = 7'(lsb); p1_t = tag;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cycle(1'b0, 0, 0, 1'b0, 0, 0, "R2");
    endtask

    function automatic int next_n();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'(lcg[20:16]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && out_enable == '0, "R9", "outputs in reset",
            64'(out_enable), 64'd0);
        rst_n = 1'b1;
        for (int k = 0; k < NSEC; k++)
            for (int i = 0; i < NEL; i++) begin
                m_w1[k][i] = 0; m_w2[k][i] = 0;
            end
        m_ord = 0; m_coef = 0;
        p1_v = 0; p2_v = 0; p1_e = '0; p2_e = '0;
    endtask

    // R9, R4: the first sample after reset takes elements 0..N-1.
    task automatic t_first_after_reset(input int n);
        do_reset();
        cycle(1'b1, n, 7'h55, 1'b0, 0, 0, "R9");
        cycle(1'b0, 0, 0, 1'b0, 0, 0, "R2");
        @(negedge clk);
        chk(out_enable == 31'((64'd1 << n) - 1), "R9", "first selection",
            64'(out_enable), (64'd1 << n) - 1);
        p1_v = 0; p2_v = 0;
        idle(2);
    endtask

    // R3, R1: extreme counts and binary patterns.
    task automatic t_extremes();
        cycle(1'b1, 0, 7'h7F, 1'b0, 0, 0, "R3");
        cycle(1'b1, 31, 7'h00, 1'b0, 0, 0, "R3");
        cycle(1'b1, 31, 7'h2A, 1'b0, 0, 0, "R3");
        cycle(1'b1, 0, 7'h15, 1'b0, 0, 0, "R3");
        idle(2);
    endtask

    // R2: a lone sample gives one strobe two edges later.
    task automatic t_latency();
        cycle(1'b1, 7, 3, 1'b0, 0, 0, "R2");
        idle(4);
    endtask

    // R5, R4, R7, R6: random-count stream under a given configuration.
    task automatic t_stream(input int ord, input int coef, input int len, input string tag);
        cycle(1'b0, 0, 0, 1'b1, ord, coef, "R8");
        for (int i = 0; i < len; i++)
            cycle(1'b1, next_n(), i & 127, 1'b0, 0, 0, tag);
        idle(2);
    endtask

    // R6: full-scale counts with a coefficient near +2 drive the sections to the clamp.
    task automatic t_saturate();
        cycle(1'b0, 0, 0, 1'b1, 2, 32000, "R8");
        for (int i = 0; i < 40; i++)
            cycle(1'b1, (i % 3 == 0) ? 31 : 1, i, 1'b0, 0, 0, "R6");
        idle(2);
    endtask

    // R10: idle gaps between samples leave the sequence unchanged.
    task automatic t_bubbles();
        cycle(1'b0, 0, 0, 1'b1, 1, -16384, "R8");
        for (int i = 0; i < 30; i++) begin
            cycle(1'b1, next_n(), i, 1'b0, 0, 0, "R10");
            if (i % 2 == 0) cycle(1'b0, 0, 0, 1'b0, 0, 0, "R10");
            if (i % 5 == 0) idle(3);
        end
        idle(2);
    endtask

    // R8: a write lands between two back-to-back samples.
    task automatic t_cfg_timing();
        cycle(1'b1, 9, 1, 1'b1, 0, 8000, "R8");
        for (int i = 0; i < 6; i++) cycle(1'b1, next_n(), i, 1'b0, 0, 0, "R8");
        cycle(1'b1, 12, 2, 1'b1, 1, -24000, "R8");
        for (int i = 0; i < 10; i++) cycle(1'b1, next_n(), i, 1'b0, 0, 0, "R8");
        cycle(1'b1, 4, 3, 1'b1, 3, 12000, "R7");
        for (int i = 0; i < 10; i++) cycle(1'b1, next_n(), i, 1'b0, 0, 0, "R7");
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        p1_v = 0; p2_v = 0; p1_e = '0; p2_e = '0; p1_l = '0; p2_l = '0;
        p1_t = "R2"; p2_t = "R2";
        t_first_after_reset(5);
        t_extremes();
        t_latency();
        // R8 reset values: order code 0, c = 0, with no write
        for (int i = 0; i < 20; i++) cycle(1'b1, next_n(), i, 1'b0, 0, 0, "R8");
        idle(2);
        t_stream(0, 0, 60, "R5");
        t_stream(0, 23170, 60, "R4");
        t_stream(1, -16384, 60, "R7");
        t_stream(2, 31130, 60, "R7");
        t_saturate();
        t_bubbles();
        t_cfg_timing();
        t_first_after_reset(17);
        t_first_after_reset(31);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule